// File: doc/BRIEF.md
# Nibble Accumulator Datapath with Carry

This block is the arithmetic slice of a small 4-bit processor core. It holds five registers:
- a 4-bit accumulator,
- a carry flag,
- a 4-bit scratch register,
- an 8-bit extension register that pairs the scratch register (high nibble) with the accumulator (low nibble),
- a 3-bit page pointer.

A decoder upstream presents one decoded operation per cycle on an opcode bus with a valid strobe. The bus carries a memory operand nibble, an immediate nibble and a 7-bit page field. The block carries the operation out at the next clock edge.

One operation, the table lookup, reaches outside the block. It forms a 14-bit ROM address from the page field, the pointer and the accumulator. It raises a one-cycle request and then waits, reporting busy, until the ROM signals ready. The 10-bit word that returns is split three ways:
- the low nibble goes to the accumulator,
- the middle nibble goes to the scratch register,
- the top two bits go to the pointer, whose top bit is cleared.

Operations that arrive during the wait are dropped.

The extension register and the pointer have no reset value. Software, or the bench, loads them before it depends on them.

Top module: `nibble_acc_dp`

## Requirements
- R1: After reset, acc_a, reg_b and carry are 0, and busy and rom_req are 0.
- R2: Opcode 1 (add with carry) sets acc_a to the low 4 bits of acc_a + mem_nib + carry, and sets carry to the carry out of that sum.
- R3: Opcode 2 (add memory) sets acc_a to (acc_a + mem_nib) mod 16, and opcode 3 (add immediate) sets it to (acc_a + imm_nib) mod 16. Neither changes carry.
- R4: Opcode 4 (rotate right through carry) sets carry to old acc_a[0] and sets acc_a to {old carry, old acc_a[3:1]}.
- R5: Opcode 5 sets carry to 1. Opcode 6 clears carry to 0.
- R6: Opcode 7 loads reg_e with {reg_b, acc_a}. Opcode 8 loads reg_b from reg_e[7:4] and acc_a from reg_e[3:0].
- R7: Opcode 9 copies acc_a into reg_b. Opcode 10 copies reg_b into acc_a.
- R8: Opcode 11 loads reg_d from imm_nib[2:0].
- R9: Opcode 12 (table lookup) takes effect at the edge where it is accepted, and from that edge:
  - rom_req is high for exactly one cycle;
  - rom_addr equals {page, reg_d, acc_a} as they stood at that edge, and holds while busy;
  - busy stays high until the edge where rom_ready is seen.
- R10: At the clock edge where busy and rom_ready are both high, acc_a takes rom_data[3:0], reg_b takes rom_data[7:4], reg_d takes {0, rom_data[9:8]}, and busy falls.
- R11: Opcodes 0, 13, 14 and 15 change no register. Any opcode presented while busy is high is ignored.
- R12: Every accepted operation updates its registers at the clock edge where op_valid is sampled high, so the result is visible one cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 4 | Decoded operation code |
| mem_nib | input | 4 | Memory operand nibble |
| imm_nib | input | 4 | Immediate nibble |
| page | input | 7 | Page field for the table lookup |
| rom_req | output | 1 | One-cycle ROM read request |
| rom_addr | output | 14 | ROM address for the lookup |
| rom_data | input | 10 | ROM word |
| rom_ready | input | 1 | ROM word valid |
| busy | output | 1 | Lookup waiting for the ROM |
| acc_a | output | 4 | Accumulator |
| reg_b | output | 4 | Scratch register |
| carry | output | 1 | Carry flag |
| reg_e | output | 8 | Extension register |
| reg_d | output | 3 | Page pointer |

## Verification
Register results follow one edge after the strobe. So do the rise of rom_req and busy after a lookup is accepted. The lookup's register results land one edge after rom_ready is seen.

The bench drives inputs on the falling edge. A behavioural model updates at the rising edge from the same inputs. The outputs are compared at the next falling edge, so each result is checked in the first cycle it is due.

The extension register and the pointer are compared only after the model has seen them written. Lookups are run with ROM latencies from zero to several cycles, and opcodes are injected during the wait.

// File: rtl/nacc_pkg.sv
package nacc_pkg;
    typedef enum logic [3:0] {
        OP_NOP  = 4'd0,
        OP_ADDC = 4'd1,
        OP_ADDM = 4'd2,
        OP_ADDI = 4'd3,
        OP_RORC = 4'd4,
        OP_SETC = 4'd5,
        OP_CLRC = 4'd6,
        OP_EPUT = 4'd7,
        OP_EGET = 4'd8,
        OP_A2B  = 4'd9,
        OP_B2A  = 4'd10,
        OP_DLD  = 4'd11,
        OP_TLK  = 4'd12
    } nacc_op_e;
endpackage

// File: rtl/nacc_alu.sv
module nacc_alu #(
    parameter int DW = 4
) (
    input  logic [DW-1:0] a_in,
    input  logic [DW-1:0] opnd,
    input  logic          cin,
    input  logic          use_cin,
    output logic [DW-1:0] sum,
    output logic          cout,
    output logic [DW-1:0] rot,
    output logic          rot_c
);
    logic [DW:0] wide;

    always_comb begin
        wide = {1'b0, a_in} + {1'b0, opnd} + {{DW{1'b0}}, (use_cin & cin)};
    end

    assign sum   = wide[DW-1:0];
    assign cout  = wide[DW];
    assign rot_c = a_in[0];

    // Rotate right through carry: each bit takes its upper neighbour.
    generate
        for (genvar i = 0; i < DW - 1; i++) begin : g_rot
            assign rot[i] = a_in[i+1];
        end
    endgenerate
    assign rot[DW-1] = cin;
endmodule

// File: rtl/nacc_lookup.sv
module nacc_lookup #(
    parameter int DW  = 4,
    parameter int DPW = 3,
    parameter int PGW = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              ready,
    input  logic [PGW-1:0]    page,
    input  logic [DPW-1:0]    ptr,
    input  logic [DW-1:0]     acc,
    output logic              req,
    output logic [PGW+DPW+DW-1:0] addr,
    output logic              busy,
    output logic              done
);
    localparam int AW = PGW + DPW + DW;

    typedef struct packed {
        logic          req;
        logic          busy;
        logic [AW-1:0] addr;
    } lk_t;

    lk_t lk_d, lk_q;

    always_comb begin
        lk_d     = lk_q;
        lk_d.req = 1'b0;
        if (!lk_q.busy && start) begin
            lk_d.req  = 1'b1;
            lk_d.busy = 1'b1;
            lk_d.addr = {page, ptr, acc};
        end else if (lk_q.busy && ready) begin
            lk_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lk_q.req  <= 1'b0;
            lk_q.busy <= 1'b0;
            lk_q.addr <= '0;
        end else begin
            lk_q <= lk_d;
        end
    end

    assign req  = lk_q.req;
    assign addr = lk_q.addr;
    assign busy = lk_q.busy;
    assign done = lk_q.busy & ready;

    // R9
    req_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !req);
    // R9
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ready) |=> (busy && $stable(addr)));
    // R9
    req_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> busy);
endmodule

// File: rtl/nibble_acc_dp.sv
module nibble_acc_dp
    import nacc_pkg::*;
#(
    parameter int DW  = 4,
    parameter int DPW = 3,
    parameter int PGW = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   op_valid,
    input  logic [3:0]             op_code,
    input  logic [DW-1:0]          mem_nib,
    input  logic [DW-1:0]          imm_nib,
    input  logic [PGW-1:0]         page,
    output logic                   rom_req,
    output logic [PGW+DPW+DW-1:0]  rom_addr,
    input  logic [2*DW+DPW-2:0]    rom_data,
    input  logic                   rom_ready,
    output logic                   busy,
    output logic [DW-1:0]          acc_a,
    output logic [DW-1:0]          reg_b,
    output logic                   carry,
    output logic [2*DW-1:0]        reg_e,
    output logic [DPW-1:0]         reg_d
);
    localparam int EW   = 2 * DW;
    localparam int ROMW = EW + DPW - 1;
    localparam int TOPW = DPW - 1;

    typedef struct packed {
        logic [DW-1:0]  a;
        logic [DW-1:0]  b;
        logic           cy;
        logic [EW-1:0]  e;
        logic [DPW-1:0] d;
    } regs_t;

    regs_t r_d, r_q;

    logic          accept, lk_start, lk_busy, lk_done;
    logic          add_with_c;
    logic [DW-1:0] alu_opnd, alu_sum, alu_rot;
    logic          alu_cout, alu_rc;

    assign accept     = op_valid && !lk_busy;
    assign lk_start   = accept && (op_code == OP_TLK);
    assign add_with_c = (op_code == OP_ADDC);
    assign alu_opnd   = (op_code == OP_ADDI) ? imm_nib : mem_nib;

    nacc_alu #(.DW(DW)) u_alu (
        .a_in    (r_q.a),
        .opnd    (alu_opnd),
        .cin     (r_q.cy),
        .use_cin (add_with_c),
        .sum     (alu_sum),
        .cout    (alu_cout),
        .rot     (alu_rot),
        .rot_c   (alu_rc)
    );

    nacc_lookup #(.DW(DW), .DPW(DPW), .PGW(PGW)) u_lk (
        .clk   (clk),
        .rst_n (rst_n),
        .start (lk_start),
        .ready (rom_ready),
        .page  (page),
        .ptr   (r_q.d),
        .acc   (r_q.a),
        .req   (rom_req),
        .addr  (rom_addr),
        .busy  (lk_busy),
        .done  (lk_done)
    );

    always_comb begin
        r_d = r_q;
        if (lk_done) begin
            r_d.a = rom_data[DW-1:0];
            r_d.b = rom_data[EW-1:DW];
            r_d.d = {1'b0, rom_data[ROMW-1 -: TOPW]};
        end else if (accept) begin
            case (op_code)
                OP_ADDC: begin
                    r_d.a  = alu_sum;
                    r_d.cy = alu_cout;
                end
                OP_ADDM, OP_ADDI: r_d.a = alu_sum;
                OP_RORC: begin
                    r_d.a  = alu_rot;
                    r_d.cy = alu_rc;
                end
                OP_SETC: r_d.cy = 1'b1;
                OP_CLRC: r_d.cy = 1'b0;
                OP_EPUT: r_d.e = {r_q.b, r_q.a};
                OP_EGET: begin
                    r_d.b = r_q.e[EW-1:DW];
                    r_d.a = r_q.e[DW-1:0];
                end
                OP_A2B: r_d.b = r_q.a;
                OP_B2A: r_d.a = r_q.b;
                OP_DLD: r_d.d = imm_nib[DPW-1:0];
                default: ;
            endcase
        end
    end

    // E and D are left without a reset value on purpose.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.a  <= '0;
            r_q.b  <= '0;
            r_q.cy <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign acc_a = r_q.a;
    assign reg_b = r_q.b;
    assign carry = r_q.cy;
    assign reg_e = r_q.e;
    assign reg_d = r_q.d;
    assign busy  = lk_busy;

    // R2
    addc_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !busy && op_code == OP_ADDC) |=>
        ({carry, acc_a} == ({1'b0, $past(acc_a)} + {1'b0, $past(mem_nib)} + {{DW{1'b0}}, $past(carry)})));
    // R3
    carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !busy && !(op_code inside {OP_ADDC, OP_RORC, OP_SETC, OP_CLRC})) |=> $stable(carry));
    // R5
    setc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !busy && op_code == OP_SETC) |=> carry);
    // R10
    lookup_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rom_ready) |=> (!busy && !reg_d[DPW-1] && acc_a == $past(rom_data[DW-1:0])));
    // R11
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rom_ready) |=> ($stable(acc_a) && $stable(reg_b) && $stable(carry) && $stable(reg_e) && $stable(reg_d)));
    // R9
    addr_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rom_req) |-> (rom_addr == {$past(page), $past(reg_d), $past(acc_a)}));
endmodule

// File: tb/sim_nibble_acc_dp.sv
module sim_nibble_acc_dp;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = '0;
    logic [3:0]  mem_nib = '0;
    logic [3:0]  imm_nib = '0;
    logic [6:0]  page = '0;
    logic [9:0]  rom_data = '0;
    logic        rom_ready = 1'b0;
    logic        rom_req, busy, carry;
    logic [13:0] rom_addr;
    logic [3:0]  acc_a, reg_b;
    logic [7:0]  reg_e;
    logic [2:0]  reg_d;

    int checks = 0;
    int errors = 0;
    bit done_flag = 0;

    // Reference model state
    int ma, mb, mc, me, md, maddr;
    bit mbusy, mreq, e_def, d_def;
    string tag = "R1";

    always #2 clk = ~clk;

    nibble_acc_dp u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .mem_nib(mem_nib), .imm_nib(imm_nib), .page(page),
        .rom_req(rom_req), .rom_addr(rom_addr), .rom_data(rom_data),
        .rom_ready(rom_ready), .busy(busy), .acc_a(acc_a), .reg_b(reg_b),
        .carry(carry), .reg_e(reg_e), .reg_d(reg_d)
    );

    function automatic int rom_fn(int adr);
        return (adr * 389 + 77) % 1024;
    endfunction

    // Behavioural model, stepped on the rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            ma = 0; mb = 0; mc = 0; mbusy = 0; mreq = 0; tag = "R1";
        end else begin
            bit nreq;
            int s;
            nreq = 0;
            if (mbusy && rom_ready) begin
                ma = rom_data % 16; mb = (rom_data / 16) % 16;
                md = rom_data / 256; d_def = 1; mbusy = 0; tag = "R10";
            end else if (op_valid && mbusy) begin
                tag = "R11";
            end else if (op_valid) begin
                case (int'(op_code))
                    1: begin s = ma + mem_nib + mc; ma = s % 16; mc = s / 16; tag = "R2"; end
                    2: begin ma = (ma + mem_nib) % 16; tag = "R3"; end
                    3: begin ma = (ma + imm_nib) % 16; tag = "R3"; end
                    4: begin s = ma % 2; ma = mc * 8 + ma / 2; mc = s; tag = "R4"; end
                    5: begin mc = 1; tag = "R5"; end
                    6: begin mc = 0; tag = "R5"; end
                    7: begin me = mb * 16 + ma; e_def = 1; tag = "R6"; end
                    8: begin mb = me / 16; ma = me % 16; tag = "R6"; end
                    9: begin mb = ma; tag = "R7"; end
                    10: begin ma = mb; tag = "R7"; end
                    11: begin md = imm_nib % 8; d_def = 1; tag = "R8"; end
                    12: begin maddr = page * 128 + md * 16 + ma; nreq = 1; mbusy = 1; tag = "R9"; end
                    default: tag = "R11";
                endcase
            end else begin
                tag = "R12";
            end
            mreq = nreq;
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Compare on every falling edge once reset has been seen.
    always @(negedge clk) begin
        if (!done_flag) begin
            chk(int'(acc_a) == ma, tag, "acc_a", acc_a, ma);
            chk(int'(reg_b) == mb, tag, "reg_b", reg_b, mb);
            chk(int'(carry) == mc, tag, "carry", carry, mc);
            chk(busy == mbusy, tag, "busy", busy, mbusy);
            chk(rom_req == mreq, tag, "rom_req", rom_req, mreq);
            if (mbusy) chk(int'(rom_addr) == maddr, "R9", "rom_addr", rom_addr, maddr);
            if (e_def) chk(int'(reg_e) == me, tag, "reg_e", reg_e, me);
            if (d_def) chk(int'(reg_d) == md, tag, "reg_d", reg_d, md);
        end
    end

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        #0.5;
    endtask

    task automatic do_op(int code, int m, int i);
        op_valid = 1; op_code = 4'(code); mem_nib = 4'(m); imm_nib = 4'(i);
        page = 7'($urandom_range(0, 127));
        step();
        op_valid = 0;
    endtask

    task automatic lookup(int lat, bit noise);
        do_op(12, 0, 0);
        for (int k = 0; k < lat; k++) begin
            op_valid = noise; op_code = 4'($urandom_range(1, 11));
            mem_nib = 4'($urandom_range(0, 15));
            step();
        end
        rom_ready = 1; rom_data = 10'(rom_fn(maddr));
        op_valid = noise; op_code = 4'($urandom_range(1, 11));
        step();
        rom_ready = 0; op_valid = 0;
    endtask

    initial begin
        #100000;
        if (!done_flag) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk); #0.5;
        step();
        // R1: reset state is compared here by the per-cycle model check
        rst_n = 1;
        step();
        do_op(11, 0, 5);        // R8
        do_op(3, 0, 15);        // R3 add immediate, A=15
        do_op(5, 0, 0);         // R5 set carry
        do_op(1, 1, 0);         // R2 15+1+1 overflow
        do_op(2, 9, 0);         // R3 add memory, carry held
        do_op(4, 0, 0);         // R4 rotate
        do_op(4, 0, 0);
        do_op(6, 0, 0);         // R5 clear carry
        do_op(9, 0, 0);         // R7 A to B
        do_op(3, 0, 6);
        do_op(7, 0, 0);         // R6 E from {B,A}
        do_op(10, 0, 0);        // R7 B to A
        do_op(8, 0, 0);         // R6 {B,A} from E
        do_op(13, 3, 3);        // R11 undefined code
        do_op(0, 3, 3);
        do_op(15, 3, 3);
        lookup(0, 0);           // R9 R10 ready in request cycle
        lookup(3, 1);           // R11 noise while busy
        lookup(1, 1);
        do_op(8, 0, 0);
        for (int n = 0; n < 600; n++) begin
            int c;
            c = $urandom_range(0, 15);
            if (c == 12) lookup($urandom_range(0, 4), 1'($urandom_range(0, 1)));
            else if ($urandom_range(0, 3) == 0) step();
            else do_op(c, $urandom_range(0, 15), $urandom_range(0, 15));
        end
        done_flag = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule